// File: doc/BRIEF.md
# Command Field Latch and Word Counter

This block sits behind the word decoder of a serial-bus remote terminal. Each time a new 16-bit command word is announced, it captures four fields on dedicated output pins. These are a broadcast flag, the transmit/receive direction, the subaddress, and a shared 5-bit count field. The host side can then route data without decoding the command again.

The 5-bit count field has several roles. Right after a command it shows the raw word-count or mode-code field. For ordinary data messages it then becomes a live index of the data word being moved, advancing once per word-transfer pulse. For receives in burst mode there is a second pass. A drain-start pulse restarts the index at zero, and the index then advances once every three clocks while the internal FIFO empties towards the system. For mode-code commands the field stays frozen on the mode code until the next command.

Top module: `cmd_field_tracker`

## Requirements
- R1: While reset is asserted, all outputs are 0.
- R2: One clock after `cmd_valid_i`, `bcast_o` is 1 when command bits [15:11] equal 31, and 0 otherwise. It then holds until the next command.
- R3: One clock after `cmd_valid_i`, `tx_o` equals command bit 10 (1 = transmit). It then holds until the next command.
- R4: One clock after `cmd_valid_i`, `subaddr_o` equals command bits [9:5]. It then holds until the next command.
- R5: One clock after `cmd_valid_i`, `wc_o` equals command bits [4:0]. It keeps that value until the first accepted word-transfer or drain pulse.
- R6: For a non-mode command, the k-th `word_xfer_i` pulse makes `wc_o` equal k-1 one clock later. The value saturates at N-1, where N is the word-count field and a field of 0 means N = 32.
- R7: For a non-mode receive captured with `burst_mode_i` = 1, a `drain_start_i` pulse makes `wc_o` 0 one clock later. It then rises by 1 every 3 clocks until N-1, and holds there.
- R8: A command whose subaddress is 0 or 31 is a mode code. `wc_o` holds the mode code, and word-transfer and drain pulses have no effect.
- R9: `drain_start_i` has no effect for transmits, for non-burst commands, and after a drain has already begun. `word_xfer_i` has no effect while a drain is running.
- R10: `cmd_valid_i` has priority over every other input. A new command replaces all fields and abandons any count or drain in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-clock pulse: new command word present |
| cmd_word_i | input | 16 | Command word: [15:11] terminal address, [10] T/R, [9:5] subaddress, [4:0] count/mode code |
| burst_mode_i | input | 1 | Sampled with the command: 1 = receive data is buffered and drained in a burst |
| word_xfer_i | input | 1 | One-clock pulse per data word transferred |
| drain_start_i | input | 1 | One-clock pulse starting the burst drain from the FIFO |
| bcast_o | output | 1 | Latched broadcast flag |
| tx_o | output | 1 | Latched transmit (1) / receive (0) flag |
| subaddr_o | output | 5 | Latched subaddress |
| wc_o | output | 5 | Word count, mode code or current word index |

## Verification
Every output is a single register, so each command field and each count step is due exactly one clock after the edge that samples the stimulus. During a drain, each further step comes three edges after the previous one. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge: it keeps the pulse tallies and the drain tick count and computes the expected value as a minimum of index and N-1. All four outputs are compared on the next falling edge, so every result is checked in the first cycle it is due and in every cycle it must hold.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned SA_W   = 5;
  localparam int unsigned WC_W   = 5;
  localparam int unsigned CMD_W  = ADDR_W + 1 + SA_W + WC_W;

  typedef struct packed {
    logic [ADDR_W-1:0] rt_addr;
    logic              tx;
    logic [SA_W-1:0]   sa;
    logic [WC_W-1:0]   wc;
  } cmd_t;

  function automatic logic is_mode_sa(input logic [SA_W-1:0] sa);
    return (sa == '0) || (sa == '1);
  endfunction

  function automatic logic is_bcast(input logic [ADDR_W-1:0] rt);
    return rt == '1;
  endfunction
endpackage

// File: rtl/cfl_field_latch.sv
module cfl_field_latch
  import cfl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  cmd_t            cmd_i,
  output logic            bcast_o,
  output logic            tx_o,
  output logic [SA_W-1:0] sa_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcast_o <= 1'b0;
      tx_o    <= 1'b0;
      sa_o    <= '0;
    end else if (load_i) begin
      bcast_o <= is_bcast(cmd_i.rt_addr);
      tx_o    <= cmd_i.tx;
      sa_o    <= cmd_i.sa;
    end
  end
endmodule

// File: rtl/cfl_word_counter.sv
module cfl_word_counter #(
  parameter int unsigned WC_W       = 5,
  parameter int unsigned DRAIN_CLKS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WC_W-1:0] field_i,
  input  logic            mode_i,
  input  logic            drain_ok_i,
  input  logic            word_xfer_i,
  input  logic            drain_start_i,
  output logic [WC_W-1:0] wc_o
);
  localparam int unsigned PH_W = (DRAIN_CLKS > 1) ? $clog2(DRAIN_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DRAIN_CLKS - 1);

  logic [WC_W-1:0] field_q, cnt_q, last;
  logic [PH_W-1:0] ph_q;
  logic            mode_q, dok_q, started_q, drain_q;

  // field 0 encodes the maximum count; wrap of the subtract gives all ones
  assign last = field_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q   <= '0;
      cnt_q     <= '0;
      ph_q      <= '0;
      mode_q    <= 1'b0;
      dok_q     <= 1'b0;
      started_q <= 1'b0;
      drain_q   <= 1'b0;
    end else if (load_i) begin
      field_q   <= field_i;
      mode_q    <= mode_i;
      dok_q     <= drain_ok_i;
      started_q <= 1'b0;
      drain_q   <= 1'b0;
      ph_q      <= '0;
      cnt_q     <= '0;
    end else if (mode_q) begin
      cnt_q <= cnt_q;
    end else if (drain_q) begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        if (cnt_q == last) drain_q <= 1'b0;
        else               cnt_q   <= cnt_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end else if (drain_start_i && dok_q) begin
      drain_q   <= 1'b1;
      started_q <= 1'b1;
      dok_q     <= 1'b0;
      cnt_q     <= '0;
      ph_q      <= '0;
    end else if (word_xfer_i) begin
      if (!started_q) begin
        started_q <= 1'b1;
        cnt_q     <= '0;
      end else if (cnt_q != last) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wc_o = started_q ? cnt_q : field_q;
endmodule

// File: rtl/cmd_field_tracker.sv
module cmd_field_tracker
  import cfl_pkg::*;
#(
  parameter int unsigned DRAIN_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             burst_mode_i,
  input  logic             word_xfer_i,
  input  logic             drain_start_i,
  output logic             bcast_o,
  output logic             tx_o,
  output logic [SA_W-1:0]  subaddr_o,
  output logic [WC_W-1:0]  wc_o
);
  cmd_t cmd;
  logic mode, drain_ok;

  assign cmd      = cmd_t'(cmd_word_i);
  assign mode     = is_mode_sa(cmd.sa);
  assign drain_ok = burst_mode_i && !cmd.tx && !mode;

  cfl_field_latch u_fields (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd_valid_i),
    .cmd_i  (cmd),
    .bcast_o(bcast_o),
    .tx_o   (tx_o),
    .sa_o   (subaddr_o)
  );

  cfl_word_counter #(
    .WC_W      (WC_W),
    .DRAIN_CLKS(DRAIN_CLKS)
  ) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (cmd_valid_i),
    .field_i      (cmd.wc),
    .mode_i       (mode),
    .drain_ok_i   (drain_ok),
    .word_xfer_i  (word_xfer_i),
    .drain_start_i(drain_start_i),
    .wc_o         (wc_o)
  );
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [15:0] cmd_word_i,
  input logic        burst_mode_i,
  input logic        word_xfer_i,
  input logic        drain_start_i,
  input logic        bcast_o,
  input logic        tx_o,
  input logic [4:0]  subaddr_o,
  input logic [4:0]  wc_o
);
  logic dok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dok_q <= 1'b0;
    else if (cmd_valid_i)
      dok_q <= burst_mode_i && !cmd_word_i[10] && cmd_word_i[9:5] != 5'd0 && cmd_word_i[9:5] != 5'd31;
  end

  always_comb if (!rst_ni) AST_RESET_ZERO: assert (!bcast_o && !tx_o && subaddr_o == '0 && wc_o == '0); // R1

  AST_BCAST_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> bcast_o == ($past(cmd_word_i[15:11]) == 5'd31)); // R2
  AST_TX_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> tx_o == $past(cmd_word_i[10])); // R3
  AST_SA_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> subaddr_o == $past(cmd_word_i[9:5])); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable({bcast_o, tx_o, subaddr_o})); // R4
  AST_WC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> wc_o == $past(cmd_word_i[4:0])); // R5
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subaddr_o == 5'd0 || subaddr_o == 5'd31) && !cmd_valid_i |=> $stable(wc_o)); // R8
  AST_DRAIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dok_q && drain_start_i && !word_xfer_i && !cmd_valid_i
      && !(subaddr_o != 5'd0 && subaddr_o != 5'd31 && $past(wc_o) != wc_o)
    |=> $stable(wc_o)); // R9
endmodule

bind cmd_field_tracker cfl_checker u_chk (.*);

// File: tb/cmd_field_tracker_test.sv
`timescale 1ns/1ps
module cmd_field_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        burst = 1'b0;
  logic        wxfer = 1'b0;
  logic        dstart = 1'b0;
  logic        bcast, tx;
  logic [4:0]  sa, wc;

  int total = 0;
  int bad = 0;
  string tag = "R5";

  always #5 clk = ~clk;

  cmd_field_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .burst_mode_i(burst), .word_xfer_i(wxfer), .drain_start_i(dstart),
    .bcast_o(bcast), .tx_o(tx), .subaddr_o(sa), .wc_o(wc)
  );

  // behavioural model
  int m_bc, m_tx, m_sa, m_field, m_last, m_mode, m_dok, m_drain, m_t, m_n;

  function automatic int exp_wc();
    int v;
    if (m_mode) return m_field;
    if (m_drain) begin v = m_t / 3; return (v < m_last) ? v : m_last; end
    if (m_n > 0) return (m_n - 1 < m_last) ? m_n - 1 : m_last;
    return m_field;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bc = 0; m_tx = 0; m_sa = 0; m_field = 0; m_last = 31; m_mode = 0;
      m_dok = 0; m_drain = 0; m_t = 0; m_n = 0;
    end else if (cmd_valid) begin
      m_bc = (cmd_word[15:11] == 31); m_tx = cmd_word[10]; m_sa = cmd_word[9:5];
      m_field = cmd_word[4:0]; m_last = (m_field == 0) ? 31 : m_field - 1;
      m_mode = (m_sa == 0 || m_sa == 31);
      m_dok = burst && !m_tx && !m_mode; m_drain = 0; m_t = 0; m_n = 0;
    end else if (!m_mode) begin
      if (m_drain) m_t++;
      else if (dstart && m_dok) begin m_drain = 1; m_t = 0; end
      else if (wxfer) m_n++;
    end
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2", bcast, m_bc);
    chk("R3", tx, m_tx);
    chk("R4", sa, m_sa);
    chk(tag, wc, exp_wc());
  end

  task automatic cyc(bit cv, logic [15:0] w, bit b, bit x, bit d);
    @(negedge clk);
    cmd_valid = cv; cmd_word = w; burst = b; wxfer = x; dstart = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, cmd_word, burst, 0, 0);
  endtask
  task automatic cmd(int rt, int t, int s, int c, bit b);
    cyc(1, {rt[4:0], t[0], s[4:0], c[4:0]}, b, 0, 0);
    cyc(0, {rt[4:0], t[0], s[4:0], c[4:0]}, 0, 0, 0);
  endtask
  task automatic words(int n, int gap);
    for (int i = 0; i < n; i++) begin cyc(0, cmd_word, 0, 1, 0); idle(gap); end
  endtask
  task automatic drain();
    cyc(0, cmd_word, 0, 0, 1);
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23;
    chk("R1", {bcast, tx, sa, wc}, 0);
    rst_n = 1'b1;
    idle(2);
    tag = "R5"; cmd(31, 0, 3, 4, 0); idle(2);
    tag = "R6"; words(5, 1);
    cmd(5, 1, 7, 0, 0); tag = "R6"; words(34, 0); idle(2);
    tag = "R5"; cmd(2, 0, 12, 3, 1); idle(1);
    tag = "R7"; words(3, 0); drain(); idle(14);
    tag = "R9"; words(2, 0); drain(); idle(3);
    cmd(4, 0, 9, 6, 0); words(1, 0); drain(); idle(4);
    cmd(4, 1, 9, 6, 1); words(2, 0); drain(); idle(4);
    cmd(8, 0, 10, 5, 1); words(5, 0); drain(); idle(2);
    words(3, 0); drain(); idle(20);
    tag = "R8"; cmd(31, 0, 31, 5, 1); words(3, 0); drain(); idle(4);
    cmd(6, 1, 0, 17, 0); words(4, 0); drain(); idle(3);
    tag = "R10"; cmd(1, 0, 14, 0, 1); words(32, 0); drain(); idle(7);
    cmd(30, 1, 21, 9, 0); idle(2); words(2, 0);
    cyc(1, {5'd31, 1'b0, 5'd2, 5'd2}, 1, 1, 1); idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule